// File: doc/BRIEF.md
# Conditional Jump Cycle Sequencer

This block sequences the bus activity of an 8-bit processor for one instruction family: the conditional absolute jump. It runs opcode fetches back to back from its program counter. When the fetched byte is a conditional jump, it selects one flag test from a 3-bit condition field in the opcode and reads the 16-bit target address that follows the opcode, low byte first. When the test passes, the program counter takes the new target. When it fails, the instruction is cut short. The low address byte is still read, because that read is committed before the decision is known. The high byte is skipped without a bus cycle, and the program counter steps over it. Any other opcode ends after its fetch, so a surrounding test can keep the stream moving.

One clock equals one clock state. An opcode fetch spans four states: ST_F1, ST_F2, ST_F3 and ST_F4. An operand read spans three: ST_L1 to ST_L3 for the low byte and ST_H1 to ST_H3 for the high byte. The transitions are:
- F1→F2→F3→F4.
- F4→L1 for a conditional jump, and F4→F1 for any other opcode.
- L1→L2→L3.
- L3→H1 when the condition holds, and L3→F1 when it fails.
- H1→H2→H3→F1.

After each instruction the block gives a one-clock completion pulse. The pulse carries a taken flag and the number of machine cycles and clock states that the instruction used.

Top module: `cjmp_seq`

## Requirements
- R1: While reset is held low, the block sits in the first fetch state. The address bus is 0x0000, the fetch marker is high, the read strobe is low, and the done pulse, the taken flag and both counts are zero.
- R2: An opcode fetch lasts four clocks, and the fetch marker is high for all four. The address bus holds the program counter for the whole fetch. The read strobe is high in the second and third clocks only, and the opcode is captured on the clock edge that ends the third clock.
- R3: A byte is a conditional jump when bits 7:6 are 11 and bits 2:0 are 010. Any other byte ends the instruction after its fetch: taken is 0, with 1 machine cycle and 4 states. The next fetch then starts at the opcode address plus 1.
- R4: Opcode bits 5:3 choose the test. The flags input is laid out as bit0 = zero, bit1 = carry, bit2 = parity, bit3 = sign. The codes are 000 zero clear, 001 zero set, 010 carry clear, 011 carry set, 100 parity clear, 101 parity set, 110 sign clear and 111 sign set.
- R5: After a conditional-jump fetch, a three-clock low-byte read at opcode address plus 1 always follows, whatever the condition result. The read strobe is high in its second and third clocks.
- R6: When the condition holds, a three-clock high-byte read at opcode address plus 2 follows. The next fetch then starts at {high byte, low byte}, and the instruction reports taken = 1, 3 machine cycles and 10 states.
- R7: When the condition fails, the high byte is never read. The next fetch starts right after the low-byte read, at opcode address plus 3, and the instruction reports taken = 0, 2 machine cycles and 7 states.
- R8: The done pulse is high for exactly one clock, in the first clock of the next fetch. Taken, the machine-cycle count and the state count are valid with it.
- R9: The flags are sampled on the clock edge that ends the fourth fetch clock. A change of the flags after that edge has no effect on the current jump.
- R10: Program-counter arithmetic wraps modulo 2^16. For example, a failed jump at 0xFFFD resumes fetching at 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one clock state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_data_i | input | 8 | Memory read data, sampled at the end of the third clock of each bus cycle |
| flags_i | input | 4 | Flags: bit0 zero, bit1 carry, bit2 parity, bit3 sign |
| addr_o | output | 16 | Address bus (current program counter) |
| rd_o | output | 1 | Memory read strobe |
| fetch_o | output | 1 | High during the four clocks of an opcode fetch |
| done_o | output | 1 | One-clock instruction completion pulse |
| taken_o | output | 1 | Jump taken, valid with done_o |
| mcyc_o | output | 2 | Machine cycles used by the finished instruction |
| tstate_o | output | 4 | Clock states used by the finished instruction |

## Verification
The instruction stream covers all eight condition codes, each with its flag both set and clear, so that taken jumps (10 states, high-byte read present) and failed jumps (7 states, no high-byte read) are both seen for every test. Non-jump bytes that match only half of the opcode pattern show that the decode needs both fields. On chosen instructions the flags are inverted in the middle of the operand read, which shows whether the decision uses the flags sampled at the end of the fetch or the live inputs. A failed jump placed at the top of memory shows the three-byte skip wrapping to address zero.

// File: rtl/cjmp_pkg.sv
package cjmp_pkg;

    typedef enum logic [3:0] {
        ST_F1, ST_F2, ST_F3, ST_F4,
        ST_L1, ST_L2, ST_L3,
        ST_H1, ST_H2, ST_H3
    } seq_state_e;

    typedef enum logic [1:0] {
        SEL_ZERO  = 2'd0,
        SEL_CARRY = 2'd1,
        SEL_PAR   = 2'd2,
        SEL_SIGN  = 2'd3
    } flag_sel_e;

    localparam int FLAG_N   = 4;
    localparam int FLAG_Z   = 0;
    localparam int FLAG_CY  = 1;
    localparam int FLAG_PAR = 2;
    localparam int FLAG_SGN = 3;

    function automatic logic is_cond_jump(input logic [7:0] op);
        return (op[7:6] == 2'b11) && (op[2:0] == 3'b010);
    endfunction

endpackage

// File: rtl/cjmp_cond.sv
module cjmp_cond
    import cjmp_pkg::*;
(
    input  logic [2:0]        code_i,
    input  logic [FLAG_N-1:0] flags_i,
    output logic              hit_o
);
    // code[2:1] picks the flag, code[0] picks the polarity that passes.
    logic picked;

    always_comb begin
        unique case (flag_sel_e'(code_i[2:1]))
            SEL_ZERO:  picked = flags_i[FLAG_Z];
            SEL_CARRY: picked = flags_i[FLAG_CY];
            SEL_PAR:   picked = flags_i[FLAG_PAR];
            SEL_SIGN:  picked = flags_i[FLAG_SGN];
            default:   picked = 1'b0;
        endcase
        hit_o = (picked == code_i[0]);
    end

endmodule

// File: rtl/cjmp_pc.sv
module cjmp_pc #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_one_i,
    input  logic              step_two_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    output logic [ADDR_W-1:0] pc_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o <= '0;
        end else if (load_i) begin
            pc_o <= load_val_i;
        end else if (step_two_i) begin
            pc_o <= pc_o + ADDR_W'(2);
        end else if (step_one_i) begin
            pc_o <= pc_o + ADDR_W'(1);
        end
    end

    // R2: the sequencer never requests two program-counter actions at once
    a_r2_one_pc_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_one_i, step_two_i, load_i}))
        else $error("a_r2_one_pc_action");

endmodule

// File: rtl/cjmp_cnt.sv
module cjmp_cnt #(
    parameter int TS_W = 4,
    parameter int MC_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mc_end_i,
    input  logic            instr_end_i,
    input  logic            took_i,
    output logic            done_o,
    output logic            taken_o,
    output logic [MC_W-1:0] mcyc_o,
    output logic [TS_W-1:0] tstate_o
);
    logic [TS_W-1:0] ts_q;
    logic [MC_W-1:0] mc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q     <= '0;
            mc_q     <= '0;
            done_o   <= 1'b0;
            taken_o  <= 1'b0;
            mcyc_o   <= '0;
            tstate_o <= '0;
        end else begin
            done_o <= instr_end_i;
            if (instr_end_i) begin
                tstate_o <= ts_q + TS_W'(1);
                mcyc_o   <= mc_q + MC_W'(1);
                taken_o  <= took_i;
                ts_q     <= '0;
                mc_q     <= '0;
            end else begin
                ts_q <= ts_q + TS_W'(1);
                if (mc_end_i) begin
                    mc_q <= mc_q + MC_W'(1);
                end
            end
        end
    end

    // R8: the completion pulse never lasts two clocks
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("a_r8_done_single");

    // R6: no instruction runs past ten states
    a_r6_ts_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ts_q <= TS_W'(9))
        else $error("a_r6_ts_bound");

endmodule

// File: rtl/cjmp_seq.sv
module cjmp_seq
    import cjmp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16,
    parameter int MC_W   = 2,
    parameter int TS_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic [FLAG_N-1:0] flags_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              rd_o,
    output logic              fetch_o,
    output logic              done_o,
    output logic              taken_o,
    output logic [MC_W-1:0]   mcyc_o,
    output logic [TS_W-1:0]   tstate_o
);
    localparam int TGT_W = 2 * DATA_W;

    seq_state_e state_q, state_d;

    logic [DATA_W-1:0] op_q, lo_q;
    logic              cond_q;
    logic              hit;
    logic              op_is_jump;

    logic cap_op, cap_lo, cap_cond;
    logic mc_end, instr_end, took;
    logic pc_step1, pc_step2, pc_load;
    logic [ADDR_W-1:0] target;

    assign op_is_jump = is_cond_jump(op_q);
    assign target     = ADDR_W'({rd_data_i, lo_q});

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_F1;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_F1: state_d = ST_F2;
            ST_F2: state_d = ST_F3;
            ST_F3: state_d = ST_F4;
            ST_F4: state_d = op_is_jump ? ST_L1 : ST_F1;
            ST_L1: state_d = ST_L2;
            ST_L2: state_d = ST_L3;
            ST_L3: state_d = cond_q ? ST_H1 : ST_F1;
            ST_H1: state_d = ST_H2;
            ST_H2: state_d = ST_H3;
            ST_H3: state_d = ST_F1;
            default: state_d = ST_F1;
        endcase
    end

    // ---------------- outputs and controls ----------------
    always_comb begin
        fetch_o   = 1'b0;
        rd_o      = 1'b0;
        cap_op    = 1'b0;
        cap_lo    = 1'b0;
        cap_cond  = 1'b0;
        mc_end    = 1'b0;
        instr_end = 1'b0;
        took      = 1'b0;
        pc_step1  = 1'b0;
        pc_step2  = 1'b0;
        pc_load   = 1'b0;
        unique case (state_q)
            ST_F1: fetch_o = 1'b1;
            ST_F2: begin
                fetch_o = 1'b1;
                rd_o    = 1'b1;
            end
            ST_F3: begin
                fetch_o = 1'b1;
                rd_o    = 1'b1;
                cap_op  = 1'b1;
            end
            ST_F4: begin
                fetch_o   = 1'b1;
                cap_cond  = 1'b1;
                pc_step1  = 1'b1;
                mc_end    = 1'b1;
                instr_end = !op_is_jump;
            end
            ST_L1: ;
            ST_L2: rd_o = 1'b1;
            ST_L3: begin
                rd_o      = 1'b1;
                cap_lo    = 1'b1;
                mc_end    = 1'b1;
                pc_step1  = cond_q;
                pc_step2  = !cond_q;
                instr_end = !cond_q;
            end
            ST_H1: ;
            ST_H2: rd_o = 1'b1;
            ST_H3: begin
                rd_o      = 1'b1;
                pc_load   = 1'b1;
                mc_end    = 1'b1;
                instr_end = 1'b1;
                took      = 1'b1;
            end
            default: ;
        endcase
    end

    // ---------------- captured operands ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= '0;
            lo_q   <= '0;
            cond_q <= 1'b0;
        end else begin
            if (cap_op)   op_q   <= rd_data_i;
            if (cap_lo)   lo_q   <= rd_data_i;
            if (cap_cond) cond_q <= hit;
        end
    end

    cjmp_cond u_cond (
        .code_i  (op_q[5:3]),
        .flags_i (flags_i),
        .hit_o   (hit)
    );

    cjmp_pc #(.ADDR_W(ADDR_W)) u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_one_i (pc_step1),
        .step_two_i (pc_step2),
        .load_i     (pc_load),
        .load_val_i (target),
        .pc_o       (addr_o)
    );

    cjmp_cnt #(.TS_W(TS_W), .MC_W(MC_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .mc_end_i    (mc_end),
        .instr_end_i (instr_end),
        .took_i      (took),
        .done_o      (done_o),
        .taken_o     (taken_o),
        .mcyc_o      (mcyc_o),
        .tstate_o    (tstate_o)
    );

    // R5: a jump fetch is always followed by the low-byte read at the next address
    a_r5_low_after_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_F4 && op_is_jump)
        |=> (state_q == ST_L1 && addr_o == $past(addr_o) + ADDR_W'(1)))
        else $error("a_r5_low_after_jump");

    // R7: a failed test skips the high byte and lands two past the low operand
    a_r7_skip_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_L3 && !cond_q)
        |=> (state_q == ST_F1 && addr_o == $past(addr_o) + ADDR_W'(2)))
        else $error("a_r7_skip_high");

    // R6: after the high-byte read the fetch address is the assembled target
    a_r6_target: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_H3)
        |=> (addr_o == ADDR_W'({$past(rd_data_i), lo_q})))
        else $error("a_r6_target");

    // R8: reported counts are one of the three legal instruction shapes
    a_r8_counts: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((mcyc_o == MC_W'(1) && tstate_o == TS_W'(4)  && !taken_o) ||
                    (mcyc_o == MC_W'(2) && tstate_o == TS_W'(7)  && !taken_o) ||
                    (mcyc_o == MC_W'(3) && tstate_o == TS_W'(10) &&  taken_o)))
        else $error("a_r8_counts");

    // R8: done appears only in the first fetch clock
    a_r8_done_at_f1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (state_q == ST_F1))
        else $error("a_r8_done_at_f1");

endmodule

// File: tb/sim_cjmp_seq.sv
module sim_cjmp_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  rd_data;
    logic [3:0]  flags;
    logic [15:0] addr;
    logic        rd, fetch, done, taken;
    logic [1:0]  mcyc;
    logic [3:0]  tstate;

    always #5 clk = ~clk;

    cjmp_seq u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_data_i (rd_data),
        .flags_i   (flags),
        .addr_o    (addr),
        .rd_o      (rd),
        .fetch_o   (fetch),
        .done_o    (done),
        .taken_o   (taken),
        .mcyc_o    (mcyc),
        .tstate_o  (tstate)
    );

    typedef struct {
        logic [15:0] addr;
        logic        rd;
        logic        fetch;
        logic [3:0]  flags;
        logic        done;
        logic        taken;
        int          mc;
        int          ts;
        string       tag_bus;
        string       tag_done;
    } exp_t;

    exp_t        q[$];
    logic [7:0]  mem [int];
    int          n_checks = 0;
    int          n_err    = 0;

    function automatic logic [7:0] rdm(input logic [15:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return 8'h00;
    endfunction

    // R4 condition table, written from the requirement
    function automatic logic cond_met(input logic [2:0] c, input logic [3:0] f);
        case (c)
            3'd0: return !f[0];
            3'd1: return  f[0];
            3'd2: return !f[1];
            3'd3: return  f[1];
            3'd4: return !f[2];
            3'd5: return  f[2];
            3'd6: return !f[3];
            default: return f[3];
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic put3(input logic [15:0] a, input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        mem[int'(a)] = b0;
        mem[int'(a + 16'd1)] = b1;
        mem[int'(a + 16'd2)] = b2;
    endtask

    task automatic load_program();
        mem[32'h0000] = 8'h00;                 // not a jump (R3)
        put3(16'h0001, 8'hC2, 8'h10, 8'h00);  // zero clear
        put3(16'h0004, 8'hCA, 8'h20, 8'h00);  // zero set
        put3(16'h0020, 8'hD2, 8'h30, 8'h00);  // carry clear
        put3(16'h0030, 8'hDA, 8'h00, 8'h01);  // carry set
        put3(16'h0033, 8'hE2, 8'h40, 8'h00);  // parity clear
        put3(16'h0040, 8'hEA, 8'h00, 8'h02);  // parity set
        put3(16'h0043, 8'hF2, 8'h50, 8'h00);  // sign clear
        put3(16'h0050, 8'hFA, 8'h00, 8'h03);  // sign set
        mem[32'h0053] = 8'hC3;                 // 11...011: not a jump
        mem[32'h0054] = 8'h02;                 // 00...010: not a jump
        put3(16'h0055, 8'hFA, 8'h00, 8'hFF);
        put3(16'hFF00, 8'hCA, 8'h60, 8'h00);
        put3(16'hFF03, 8'hC2, 8'hFD, 8'hFF);
        put3(16'hFFFD, 8'hD2, 8'h00, 8'h70);  // failed jump wraps (R10)
        put3(16'h0100, 8'hCA, 8'h00, 8'h00);
        put3(16'h0200, 8'hC2, 8'h01, 8'h00);
        put3(16'h0300, 8'hD2, 8'h00, 8'h00);
        put3(16'h0060, 8'hDA, 8'h04, 8'h00);
    endtask

    // behavioural instruction-level model expanded into one entry per clock
    task automatic build_model(input int ni);
        logic [15:0] pc = 16'h0000;
        logic [7:0]  seed = 8'hA5;
        logic        pend_done = 1'b0;
        logic        pend_taken = 1'b0;
        int          pend_mc = 0, pend_ts = 0;
        string       pend_tag = "R3";
        string       arr_tag = "R2";
        logic [3:0]  fixed [15] = '{4'h0, 4'h1, 4'h1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0,
                                    4'h0, 4'h0, 4'h0, 4'h8, 4'h0, 4'h0, 4'h2};
        for (int i = 0; i < ni; i++) begin
            logic [3:0] f0;
            logic       flip;
            logic [7:0] op;
            int         base;
            seed = {seed[6:0], seed[7] ^ seed[5] ^ seed[4] ^ seed[3]};
            f0   = (i < 15) ? fixed[i] : seed[3:0];
            flip = (i == 3) || (i == 12) || (i >= 15 && (i % 3) == 0);
            op   = rdm(pc);
            base = q.size();
            for (int k = 0; k < 4; k++) begin
                exp_t e;
                e.addr = pc; e.rd = (k == 1 || k == 2); e.fetch = 1'b1;
                e.done = (k == 0) ? pend_done : 1'b0;
                e.taken = pend_taken; e.mc = pend_mc; e.ts = pend_ts;
                e.tag_bus = (k == 0) ? arr_tag : "R2";
                e.tag_done = pend_tag;
                q.push_back(e);
            end
            pend_done = 1'b1;
            if (!(op[7:6] == 2'b11 && op[2:0] == 3'b010)) begin
                pend_taken = 1'b0; pend_mc = 1; pend_ts = 4; pend_tag = "R3";
                arr_tag = "R3";
                pc = pc + 16'd1;
            end else begin
                logic       hit;
                logic [7:0] lo, hi;
                hit = cond_met(op[5:3], f0);
                for (int k = 0; k < 3; k++) begin
                    exp_t e;
                    e.addr = pc + 16'd1; e.rd = (k != 0); e.fetch = 1'b0;
                    e.done = 1'b0; e.taken = 1'b0; e.mc = 0; e.ts = 0;
                    e.tag_bus = "R5"; e.tag_done = "R8";
                    q.push_back(e);
                end
                lo = rdm(pc + 16'd1);
                if (hit) begin
                    for (int k = 0; k < 3; k++) begin
                        exp_t e;
                        e.addr = pc + 16'd2; e.rd = (k != 0); e.fetch = 1'b0;
                        e.done = 1'b0; e.taken = 1'b0; e.mc = 0; e.ts = 0;
                        e.tag_bus = "R6"; e.tag_done = "R8";
                        q.push_back(e);
                    end
                    hi = rdm(pc + 16'd2);
                    pc = {hi, lo};
                    pend_taken = 1'b1; pend_mc = 3; pend_ts = 10;
                    pend_tag = flip ? "R9" : "R6";
                    arr_tag = "R6";
                end else begin
                    arr_tag = (pc + 16'd3 < pc) ? "R10" : "R7";
                    pc = pc + 16'd3;
                    pend_taken = 1'b0; pend_mc = 2; pend_ts = 7;
                    pend_tag = flip ? "R9" : "R7";
                end
            end
            for (int k = base; k < q.size(); k++) begin
                q[k].flags = (flip && (k - base) >= 5) ? ~f0 : f0;
            end
        end
        begin
            exp_t e;
            e.addr = pc; e.rd = 1'b0; e.fetch = 1'b1; e.flags = 4'h0;
            e.done = pend_done; e.taken = pend_taken; e.mc = pend_mc; e.ts = pend_ts;
            e.tag_bus = arr_tag; e.tag_done = pend_tag;
            q.push_back(e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL R8 watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        flags   = 4'h0;
        rd_data = 8'h00;
        load_program();
        build_model(45);
        repeat (3) @(negedge clk);
        chk("R1", "reset addr",   addr,   0);
        chk("R1", "reset rd",     rd,     0);
        chk("R1", "reset fetch",  fetch,  1);
        chk("R1", "reset done",   done,   0);
        chk("R1", "reset taken",  taken,  0);
        chk("R1", "reset mcyc",   mcyc,   0);
        chk("R1", "reset tstate", tstate, 0);
        rst_n = 1'b1;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag_bus, "address", addr,  e.addr);
            chk(e.tag_bus, "read strobe", rd, e.rd);
            chk(e.tag_bus, "fetch marker", fetch, e.fetch);
            chk("R8", "done", done, e.done);
            if (e.done) begin
                chk(e.tag_done, "taken (R4 test)", taken, e.taken);
                chk(e.tag_done, "machine cycles", mcyc, e.mc);
                chk(e.tag_done, "states", tstate, e.ts);
            end
            flags   = e.flags;
            rd_data = rdm(addr);
            @(negedge clk);
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule